// File: doc/BRIEF.md
# Packet-Header I2C Master Sequencer

This block runs an I2C master from a stream of 32-bit words in a transmit FIFO. Each message opens with three header words. The first word is popped and not decoded. The second word gives the payload length minus one. The third word carries the target address and the per-message flags.

From the header the block sends byte-level commands to a bus-phase stage: start, address bytes, data writes or reads, and then a stop, a repeated start, or nothing. Write payload is taken out of FIFO words least significant byte first. Read bytes are packed into words for a receive FIFO. Single-cycle event pulses report packet completion, a missing acknowledge and lost arbitration.

The block is placed between a software-filled word FIFO and the bit-timing logic that drives SCL and SDA. Bit-level timing is not part of this block. Each bus action is one request held on the command port until the bus stage returns a one-cycle completion with its response.

Top module: `i2c_pkt_master`

## Requirements
- R1: Every message takes exactly three header words from the transmit FIFO, popping one word per cycle and only while `tx_valid` is high. The low `LEN_W` bits of the second word hold the byte count minus one. Content of the first word is not decoded.
- R2: A command is held on `cmd_valid`/`cmd_op`/`cmd_byte` without change until the cycle in which `cmd_done` is high. The `cmd_op` codes are: 1 start, 2 repeated start, 3 write byte, 4 read byte, 5 stop. No FIFO word is popped while a command is pending.
- R3: When bit 18 of the third word is clear, bits 7:1 hold a 7-bit address, sent as one write byte {addr[6:0], rd}. When bit 18 is set, bits 9:0 hold a 10-bit address, sent as two write bytes: {5'b11110, a[9:8], rd} and then a[7:0]. Bit 19 selects read (rd = 1).
- R4: On a write, payload bytes are sent from each word least significant byte first. When the length is not a multiple of four, the unused upper bytes of the last word are never sent.
- R5: On a read, one read command (op 4) is issued per byte. `cmd_byte[0]` is 1 only on the final byte, which asks for a not-acknowledge. Received bytes are packed least significant first into a word. The word is pushed when four bytes are held or the final byte arrives, and its unused upper bytes are zero.
- R6: The end of a message is chosen from the third word. If bit 15 is set, no end command is issued and the next message begins directly with data, with no start and no address. Otherwise, if bit 16 is set, a repeated start is issued and the next message skips its start but sends its address. Otherwise a stop is issued.
- R7: When bit 17 is set, `evt_done` pulses one cycle after the completion of the last write byte, or one cycle after the push of the last read word. When bit 17 is clear, it never pulses.
- R8: A write byte completed with `rsp_ack` low raises `evt_nack` one cycle later. If bit 21 is clear, the message is abandoned: a stop is issued, no `evt_done` is raised, and any unread payload words stay in the FIFO. If bit 21 is set, the message carries on as if the byte had been acknowledged.
- R9: A completion with `rsp_arb` high raises `evt_arb` one cycle later. No further command is issued for that message, and the next message begins with a full start.
- R10: While the transmit FIFO is empty or `rx_full` is high, the block waits with no command, no push and no event. It resumes when the condition clears.
- R11: During and just after reset there is no command, no pop, no push and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 32 | Word at the head of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_pop | output | 1 | Takes the head word this cycle |
| rx_data | output | 32 | Packed receive word |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| cmd_valid | output | 1 | Bus command pending |
| cmd_op | output | 3 | Command code (see R2) |
| cmd_byte | output | 8 | Write byte, or not-acknowledge flag in bit 0 for reads |
| cmd_done | input | 1 | Bus stage finished the pending command |
| rsp_ack | input | 1 | Target acknowledged the written byte |
| rsp_arb | input | 1 | Arbitration was lost during the command |
| rsp_byte | input | 8 | Byte received by a read command |
| evt_done | output | 1 | Packet-complete pulse |
| evt_nack | output | 1 | Missing-acknowledge pulse |
| evt_arb | output | 1 | Arbitration-lost pulse |

## Verification
Commands appear at the port in the first cycle after the block enters a state, so the bench compares each command in the cycle where `cmd_done` is high. Received words are compared in the cycle where `rx_push` is high. Each event pulse is due exactly one cycle after the completion or push that causes it, and the monitor checks pulses in the order they occur. All sampling is done on the falling clock edge, against queues that the driver fills from the header fields it writes. Stall checks count the commands still queued at a fixed cycle, then watch the command and push outputs stay idle over a window of cycles.

// File: rtl/i2c_pkt_master.sv
module i2c_pkt_master #(
  parameter int LEN_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tx_data,
  input  logic        tx_valid,
  output logic        tx_pop,
  output logic [31:0] rx_data,
  output logic        rx_push,
  input  logic        rx_full,
  output logic        cmd_valid,
  output logic [2:0]  cmd_op,
  output logic [7:0]  cmd_byte,
  input  logic        cmd_done,
  input  logic        rsp_ack,
  input  logic        rsp_arb,
  input  logic [7:0]  rsp_byte,
  output logic        evt_done,
  output logic        evt_nack,
  output logic        evt_arb
);
  localparam logic [2:0] OP_START = 3'd1, OP_RSTART = 3'd2, OP_WR = 3'd3,
                         OP_RD = 3'd4, OP_STOP = 3'd5;

  typedef enum logic [3:0] {S_H0, S_H1, S_H2, S_START, S_ADR1, S_ADR2,
                            S_LOAD, S_WR, S_RD, S_PUSH, S_FIN} st_t;
  st_t st;

  logic [LEN_W-1:0] rem;
  logic [1:0]  bidx;
  logic [31:0] wbuf, acc;
  logic [9:0]  addr;
  logic f_cont, f_rs, f_ie, f_ten, f_rd, f_cnak;
  logic kill, skip_start, skip_addr;
  logic unused_hdr;

  wire fin_silent = (st == S_FIN) && f_cont && !kill;
  wire hs         = cmd_valid && cmd_done;
  wire nak        = hs && !rsp_ack && (cmd_op == OP_WR);
  wire abort_nak  = nak && !f_cnak;
  wire last       = (rem == '0);

  assign unused_hdr = ^tx_data;
  assign tx_pop  = tx_valid && (st == S_H0 || st == S_H1 || st == S_H2 || st == S_LOAD);
  assign rx_push = (st == S_PUSH) && !rx_full;
  assign rx_data = acc;
  assign cmd_valid = (st == S_START || st == S_ADR1 || st == S_ADR2 || st == S_WR ||
                      st == S_RD || (st == S_FIN && !fin_silent));

  always_comb begin
    cmd_op   = 3'd0;
    cmd_byte = 8'h00;
    case (st)
      S_START: cmd_op = OP_START;
      S_ADR1: begin
        cmd_op   = OP_WR;
        cmd_byte = f_ten ? {5'b11110, addr[9:8], f_rd} : {addr[7:1], f_rd};
      end
      S_ADR2: begin
        cmd_op   = OP_WR;
        cmd_byte = addr[7:0];
      end
      S_WR: begin
        cmd_op   = OP_WR;
        cmd_byte = wbuf[{bidx, 3'b000} +: 8];
      end
      S_RD: begin
        cmd_op   = OP_RD;
        cmd_byte = {7'b0, last};
      end
      S_FIN: cmd_op = (!kill && f_rs) ? OP_RSTART : OP_STOP;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_H0;
      rem <= '0; bidx <= '0; wbuf <= '0; acc <= '0; addr <= '0;
      f_cont <= 1'b0; f_rs <= 1'b0; f_ie <= 1'b0; f_ten <= 1'b0; f_rd <= 1'b0; f_cnak <= 1'b0;
      kill <= 1'b0; skip_start <= 1'b0; skip_addr <= 1'b0;
      evt_done <= 1'b0; evt_nack <= 1'b0; evt_arb <= 1'b0;
    end else begin
      evt_done <= 1'b0;
      evt_nack <= 1'b0;
      evt_arb  <= 1'b0;
      if (hs && rsp_arb) begin
        evt_arb    <= 1'b1;
        st         <= S_H0;
        skip_start <= 1'b0;
        skip_addr  <= 1'b0;
      end else begin
        if (nak) evt_nack <= 1'b1;
        case (st)
          S_H0: if (tx_valid) st <= S_H1;
          S_H1: if (tx_valid) begin
            rem <= tx_data[LEN_W-1:0];
            st  <= S_H2;
          end
          S_H2: if (tx_valid) begin
            f_cont <= tx_data[15];
            f_rs   <= tx_data[16];
            f_ie   <= tx_data[17];
            f_ten  <= tx_data[18];
            f_rd   <= tx_data[19];
            f_cnak <= tx_data[21];
            addr   <= tx_data[9:0];
            kill <= 1'b0; bidx <= '0; acc <= '0;
            skip_start <= 1'b0; skip_addr <= 1'b0;
            if (skip_addr)       st <= tx_data[19] ? S_RD : S_LOAD;
            else if (skip_start) st <= S_ADR1;
            else                 st <= S_START;
          end
          S_START: if (hs) st <= S_ADR1;
          S_ADR1, S_ADR2: if (hs) begin
            if (abort_nak) begin
              kill <= 1'b1;
              st   <= S_FIN;
            end else if (st == S_ADR1 && f_ten) st <= S_ADR2;
            else st <= f_rd ? S_RD : S_LOAD;
          end
          S_LOAD: if (tx_valid) begin
            wbuf <= tx_data;
            st   <= S_WR;
          end
          S_WR: if (hs) begin
            if (abort_nak) begin
              kill <= 1'b1;
              st   <= S_FIN;
            end else if (last) begin
              evt_done <= f_ie;
              st       <= S_FIN;
            end else begin
              rem  <= rem - 1'b1;
              bidx <= bidx + 2'd1;
              st   <= (bidx == 2'd3) ? S_LOAD : S_WR;
            end
          end
          S_RD: if (hs) begin
            acc[{bidx, 3'b000} +: 8] <= rsp_byte;
            if (last || bidx == 2'd3) st <= S_PUSH;
            else begin
              rem  <= rem - 1'b1;
              bidx <= bidx + 2'd1;
            end
          end
          S_PUSH: if (!rx_full) begin
            acc  <= '0;
            bidx <= '0;
            if (last) begin
              evt_done <= f_ie;
              st       <= S_FIN;
            end else begin
              rem <= rem - 1'b1;
              st  <= S_RD;
            end
          end
          S_FIN: begin
            if (fin_silent) begin
              skip_addr <= 1'b1;
              st        <= S_H0;
            end else if (hs) begin
              skip_start <= !kill && f_rs;
              st         <= S_H0;
            end
          end
          default: st <= S_H0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_pkt_master_chk.sv
module i2c_pkt_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_pop,
  input logic       rx_push,
  input logic       rx_full,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       cmd_done,
  input logic       rsp_ack,
  input logic       evt_done,
  input logic       evt_nack,
  input logic       evt_arb
);
  a_r1_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);

  a_r2_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));

  a_r2_no_pop_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !tx_pop);

  a_r10_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  a_r8_nack_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    evt_nack |-> $past(cmd_valid && cmd_done && cmd_op == 3'd3 && !rsp_ack));

  a_r9_arb_goes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    evt_arb |-> !cmd_valid && !evt_done);
endmodule

bind i2c_pkt_master i2c_pkt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_pop(tx_pop),
  .rx_push(rx_push), .rx_full(rx_full), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_done(cmd_done),
  .rsp_ack(rsp_ack), .evt_done(evt_done), .evt_nack(evt_nack), .evt_arb(evt_arb)
);

// File: tb/i2c_pkt_master_test.sv
module i2c_pkt_master_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [31:0] tx_data;
  logic        tx_valid, tx_pop;
  logic [31:0] rx_data;
  logic        rx_push;
  logic        rx_full = 1'b0;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic        cmd_done = 1'b0, rsp_ack = 1'b1, rsp_arb = 1'b0;
  logic [7:0]  rsp_byte = 8'h00;
  logic        evt_done, evt_nack, evt_arb;

  i2c_pkt_master uut (.*);

  int checks = 0, fails = 0;
  logic [31:0] txmem [0:255];
  int wr_p = 0, rd_p = 0;
  logic tx_en = 1'b1;
  assign tx_valid = tx_en && (rd_p < wr_p);
  assign tx_data  = txmem[rd_p[7:0]];
  always @(posedge clk) if (tx_pop) rd_p <= rd_p + 1;

  int fault_cnt = 0, fault_kind = 0, wt = 0, rdcnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      cmd_done <= 1'b0; wt = 0;
    end else if (cmd_done) cmd_done <= 1'b0;
    else if (cmd_valid) begin
      if (wt == 2) begin
        bit flt;
        wt = 0;
        flt = (fault_cnt == 1);
        if (fault_cnt > 0) fault_cnt = fault_cnt - 1;
        cmd_done <= 1'b1;
        rsp_ack  <= !(flt && fault_kind == 0);
        rsp_arb  <= flt && fault_kind == 1;
        if (cmd_op == 3'd4) begin
          rsp_byte <= 8'h5A ^ 8'(rdcnt);
          rdcnt = rdcnt + 1;
        end
      end else wt = wt + 1;
    end
  end

  logic [10:0] exp_cmd[$];
  string       exp_tag[$];
  logic [31:0] exp_rx[$];
  int          exp_evt[$];
  logic [31:0] pend[$];
  int rdexp = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_evt(input int code);
    string r;
    r = (code == 1) ? "R7" : (code == 2) ? "R8" : "R9";
    if (exp_evt.size() == 0) check(0, r, "unexpected event", code, 0);
    else begin
      int e;
      e = exp_evt.pop_front();
      check(e == code, r, "event order", code, e);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid && cmd_done) begin
      if (exp_cmd.size() == 0) check(0, "R2", "unexpected command", {cmd_op, cmd_byte}, 0);
      else begin
        logic [10:0] e;
        string t;
        e = exp_cmd.pop_front();
        t = exp_tag.pop_front();
        check({cmd_op, cmd_byte} == e, t, "command {op,byte}", {cmd_op, cmd_byte}, e);
      end
    end
    if (rx_push) begin
      if (exp_rx.size() == 0) check(0, "R5", "unexpected rx word", rx_data, 0);
      else begin
        logic [31:0] e;
        e = exp_rx.pop_front();
        check(rx_data == e, "R5", "rx word", rx_data, e);
      end
    end
    if (evt_nack) chk_evt(2);
    if (evt_done) chk_evt(1);
    if (evt_arb)  chk_evt(3);
  end

  task automatic push_word(input logic [31:0] w);
    txmem[wr_p[7:0]] = w;
    wr_p++;
  endtask

  task automatic exp_c(input logic [2:0] op, input logic [7:0] b, input string tag);
    exp_cmd.push_back({op, b});
    exp_tag.push_back(tag);
  endtask

  // pre: 0 full start, 1 address only, 2 neither
  task automatic run_msg(input bit rd, input bit ten, input bit rs, input bit cont,
                         input bit cnak, input bit ie, input logic [9:0] adr,
                         input int len, input int pre, input bit hold);
    logic [31:0] w2, word;
    logic [7:0] b;
    w2 = (32'(cont) << 15) | (32'(rs) << 16) | (32'(ie) << 17) | (32'(ten) << 18) |
         (32'(rd) << 19) | (32'(cnak) << 21) | (ten ? 32'(adr) : (32'(adr[6:0]) << 1));
    push_word(32'h0001_0010);
    push_word(32'(len - 1));
    push_word(w2);
    if (pre == 0) exp_c(3'd1, 8'h00, "R6");
    if (pre < 2) begin
      if (ten) begin
        exp_c(3'd3, {5'b11110, adr[9:8], rd}, "R3");
        exp_c(3'd3, adr[7:0], "R3");
      end else exp_c(3'd3, {adr[6:0], rd}, "R3");
    end
    word = 32'hEEEE_EEEE;
    for (int i = 0; i < len; i++) begin
      if (!rd) begin
        b = 8'(8'h3C + i * 53 + len);
        word[8*(i%4) +: 8] = b;
        exp_c(3'd3, b, "R4");
        if (i % 4 == 3 || i == len - 1) begin
          if (hold) pend.push_back(word); else push_word(word);
          word = 32'hEEEE_EEEE;
        end
      end else begin
        if (i % 4 == 0) word = 32'h0;
        exp_c(3'd4, {7'b0, i == len - 1}, "R5");
        word[8*(i%4) +: 8] = 8'h5A ^ 8'(rdexp);
        rdexp++;
        if (i % 4 == 3 || i == len - 1) exp_rx.push_back(word);
      end
    end
    if (ie) exp_evt.push_back(1);
    if (!cont) exp_c(rs ? 3'd2 : 3'd5, 8'h00, "R6");
  endtask

  task automatic settle;
    while (exp_cmd.size() != 0 || exp_rx.size() != 0 || exp_evt.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic main_flow;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!cmd_valid && !tx_pop && !rx_push, "R11", "idle in reset",
          {cmd_valid, tx_pop, rx_push}, 0);
    check(!evt_done && !evt_nack && !evt_arb, "R11", "no event in reset",
          {evt_done, evt_nack, evt_arb}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!cmd_valid && !tx_pop, "R11", "idle after reset", {cmd_valid, tx_pop}, 0);

    // 7-bit write, 5 bytes, stop
    run_msg(0, 0, 0, 0, 0, 1, 10'h052, 5, 0, 0);
    settle();
    // 7-bit read, 6 bytes, repeated start
    run_msg(1, 0, 1, 0, 0, 1, 10'h02B, 6, 0, 0);
    settle();
    // after repeated start: 10-bit write with continue, no completion event
    run_msg(0, 1, 0, 1, 0, 0, 10'h2A7, 2, 1, 0);
    settle();
    // after continue: data only, then stop
    run_msg(0, 0, 0, 0, 0, 1, 10'h010, 1, 2, 0);
    settle();

    // R8 address nack without continue-on-nack: stop, no done
    fault_kind = 0; fault_cnt = 2;
    push_word(32'h0001_0010); push_word(32'd2); push_word((32'h1 << 17) | (32'h33 << 1));
    exp_c(3'd1, 8'h00, "R8");
    exp_c(3'd3, {7'h33, 1'b0}, "R8");
    exp_c(3'd5, 8'h00, "R8");
    exp_evt.push_back(2);
    settle();

    // R8 data nack with continue-on-nack: message completes
    fault_kind = 0; fault_cnt = 3;
    exp_evt.push_back(2);
    run_msg(0, 0, 0, 0, 1, 1, 10'h021, 2, 0, 0);
    settle();

    // R9 arbitration lost on a data byte, repeated start requested
    fault_kind = 1; fault_cnt = 3;
    push_word(32'h0001_0010); push_word(32'd0);
    push_word((32'h1 << 16) | (32'h1 << 17) | (32'h44 << 1));
    push_word(32'hEEEE_EEC3);
    exp_c(3'd1, 8'h00, "R9");
    exp_c(3'd3, {7'h44, 1'b0}, "R9");
    exp_c(3'd3, 8'hC3, "R9");
    exp_evt.push_back(3);
    settle();
    fault_kind = 0;
    // R9 next message must start with a full start
    run_msg(0, 0, 0, 0, 0, 1, 10'h05E, 1, 0, 0);
    settle();

    // R10 empty transmit FIFO stall
    run_msg(0, 0, 0, 0, 0, 1, 10'h061, 8, 0, 1);
    repeat (60) @(negedge clk);
    check(exp_cmd.size() == 9, "R10", "commands left while TX empty", exp_cmd.size(), 9);
    for (int i = 0; i < 20; i++) begin
      check(!cmd_valid && !evt_done && !evt_nack && !evt_arb, "R10",
            "quiet while TX empty", {cmd_valid, evt_done, evt_nack, evt_arb}, 0);
      @(negedge clk);
    end
    while (pend.size() != 0) push_word(pend.pop_front());
    settle();

    // R10 full receive FIFO stall
    rx_full = 1'b1;
    run_msg(1, 0, 0, 0, 0, 1, 10'h07A, 6, 0, 0);
    repeat (80) @(negedge clk);
    check(exp_rx.size() == 2, "R10", "words left while RX full", exp_rx.size(), 2);
    for (int i = 0; i < 20; i++) begin
      check(!rx_push && !cmd_valid, "R10", "quiet while RX full", {rx_push, cmd_valid}, 0);
      @(negedge clk);
    end
    rx_full = 1'b0;
    settle();

    check(rd_p == wr_p, "R1", "all header and payload words taken", rd_p, wr_p);
  endtask

  initial begin
    fork
      main_flow();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule